// File: doc/BRIEF.md
# Set/Clear Control Register Bank with Strap Protection

This block is a bank of 32-bit control words on a simple request/response bus. Some control words are split into two addresses. A write to the data address ORs the write data into the word. A write to the address one word above clears, in the data word, every bit that is 1 in the write data. Two strap words use the same set/clear pair. A protect word sits two words above each strap word, and while that protect word is nonzero, set writes to the strap are refused. Clear writes to the strap still work.

Reads of the three PLL extension words always return bit 31 as 1, which reports the PLL as locked. The bank also has several other words:
- a key flag at word 0, which holds 1 only after the matching key value is written there;
- two revision words and two identification words, all read-only;
- a random-data word that captures a new value from a free-running LFSR on every read.

Every other aligned word in the 4 KiB window is ordinary read/write storage.

Each request is answered exactly one cycle later. The answer carries read data, an error pulse when a write is refused or the access is misaligned, and a lock-hit pulse when software writes above the key word while the key flag is 0. That write is still performed.

Top module: `scb_bank`

## Requirements
- R1: A write to byte address 0x040, 0x050, 0x080 or 0x090 ORs the write data into that word.
- R2: A write to 0x044, 0x054, 0x084 or 0x094 clears, in the word at the address minus 4, each bit that is 1 in the write data. The clear address itself stores nothing.
- R3: A write to a strap word (0x500, 0x510) ORs in the data only when its protect word (0x508, 0x518) is zero. Otherwise the write is dropped and err_o pulses. The strap clear addresses (0x504, 0x514) clear bits in the strap word whatever the protect word holds.
- R4: A read of 0x204, 0x224 or 0x244 returns the stored word with bit 31 forced to 1. Writes to these words store the data as given.
- R5: Writes to 0x004, 0x014, 0x5B0, 0x5B4 and 0x540 change nothing and pulse err_o.
- R6: Each read of 0x540 returns the current state of a 32-bit Galois LFSR and also stores it in that word. The LFSR is seeded with 0x00000001 at reset and steps every cycle as s = (s >> 1) XOR (s[0] ? 0x80200003 : 0).
- R7: A write to 0x000 stores 1 if the data equals KEY (default 0x5A17C3E9) and 0 otherwise. A read of 0x000 returns that flag.
- R8: A write to any aligned address other than 0x000 while the key flag is 0 pulses lock_hit_o one cycle later. The write still takes its normal effect.
- R9: After reset the bank holds the following values. Every other word is 0, including the key flag.

  | Address | Value |
  |---|---|
  | 0x040 | 0xF7C3FED8 |
  | 0x050 | 0x0DFFFFFC |
  | 0x080 | 0xFFFF7F8A |
  | 0x090 | 0xFFF0FFF0 |
  | 0x200 | 0x1000408F |
  | 0x5B0 | 0x1234ABCD |
  | 0x5B4 | 0x88884444 |
  | 0x004 | REV_WORD (default 0x0A110001) |
  | 0x014 | value on rev_i during reset |

- R10: An access with addr_i[1:0] not 00 has no effect, returns rdata_o = 0 and pulses err_o.
- R11: Every request gives rvalid_o exactly one cycle later, with no response in other cycles. rdata_o carries the read value for reads and is 0 otherwise. Every other aligned word is plain storage that reads back what was last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request strobe, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| rev_i | input | 32 | Revision value loaded into 0x014 at reset |
| rvalid_o | output | 1 | Response valid, one cycle after req_i |
| rdata_o | output | 32 | Read data |
| err_o | output | 1 | Refused write or misaligned access |
| lock_hit_o | output | 1 | Write above word 0 while the key flag is 0 |

## Verification
A behavioural model in the bench is compared with the outputs on every clock. Directed set and clear writes use overlapping bit patterns, so a wrong target word or an inverted mask shows up as a wrong read-back. The strap sequence first runs with the protect word zero and then with it nonzero. This separates a blocked set from a clear that must still work. Wrong and correct key values, read-only targets, misaligned offsets and repeated random-word reads follow. The last phase is a long mixed random stream over every address class, which exposes interactions such as a lock pulse alongside a refused write.

// File: rtl/scb_pkg.sv
package scb_pkg;

    localparam int unsigned DW = 32;

    typedef enum logic [3:0] {
        K_PLAIN,
        K_KEY,
        K_SET,
        K_CLR,
        K_STRAP_SET,
        K_STRAP_CLR,
        K_PLLX,
        K_RO,
        K_RNG,
        K_BAD
    } acc_kind_e;

    // byte addresses of the special words
    localparam logic [11:0] A_KEY    = 12'h000;
    localparam logic [11:0] A_REV0   = 12'h004;
    localparam logic [11:0] A_REV1   = 12'h014;
    localparam logic [11:0] A_RST0   = 12'h040;
    localparam logic [11:0] A_RST1   = 12'h050;
    localparam logic [11:0] A_GATE0  = 12'h080;
    localparam logic [11:0] A_GATE1  = 12'h090;
    localparam logic [11:0] A_PLLH   = 12'h200;
    localparam logic [11:0] A_PLLX0  = 12'h204;
    localparam logic [11:0] A_PLLX1  = 12'h224;
    localparam logic [11:0] A_PLLX2  = 12'h244;
    localparam logic [11:0] A_STRAP0 = 12'h500;
    localparam logic [11:0] A_STRAP1 = 12'h510;
    localparam logic [11:0] A_RNG    = 12'h540;
    localparam logic [11:0] A_ID0    = 12'h5B0;
    localparam logic [11:0] A_ID1    = 12'h5B4;

    localparam logic [DW-1:0] RV_RST0  = 32'hF7C3_FED8;
    localparam logic [DW-1:0] RV_RST1  = 32'h0DFF_FFFC;
    localparam logic [DW-1:0] RV_GATE0 = 32'hFFFF_7F8A;
    localparam logic [DW-1:0] RV_GATE1 = 32'hFFF0_FFF0;
    localparam logic [DW-1:0] RV_PLLH  = 32'h1000_408F;
    localparam logic [DW-1:0] RV_ID0   = 32'h1234_ABCD;
    localparam logic [DW-1:0] RV_ID1   = 32'h8888_4444;

    localparam int unsigned LOCK_BIT = 31;

endpackage

// File: rtl/scb_lfsr.sv
module scb_lfsr #(
    parameter int unsigned        W    = 32,
    parameter logic [W-1:0]       TAPS = 32'h8020_0003,
    parameter logic [W-1:0]       SEED = 32'h0000_0001
) (
    input  logic         clk_i,
    input  logic         rst_i,
    output logic [W-1:0] state_o
);
    logic [W-1:0] s_d, s_q;

    always_comb begin
        s_d = (s_q >> 1) ^ (s_q[0] ? TAPS : '0);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) s_q <= SEED;
        else       s_q <= s_d;
    end

    assign state_o = s_q;

    a_r6_never_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        s_q != '0);
endmodule

// File: rtl/scb_decode.sv
module scb_decode
    import scb_pkg::*;
#(
    parameter int unsigned AW = 12
) (
    input  logic [AW-1:0] addr_i,
    output acc_kind_e     kind_o
);
    localparam int unsigned NSET = 4;
    localparam int unsigned NPLL = 3;
    localparam logic [AW-1:0] SET_ADDR [NSET] = '{A_RST0, A_RST1, A_GATE0, A_GATE1};
    localparam logic [AW-1:0] PLL_ADDR [NPLL] = '{A_PLLX0, A_PLLX1, A_PLLX2};

    logic [NSET-1:0] hit_set, hit_clr;
    logic [NPLL-1:0] hit_pll;

    for (genvar i = 0; i < NSET; i++) begin : g_set
        assign hit_set[i] = (addr_i == SET_ADDR[i]);
        assign hit_clr[i] = (addr_i == SET_ADDR[i] + AW'(4));
    end
    for (genvar j = 0; j < NPLL; j++) begin : g_pll
        assign hit_pll[j] = (addr_i == PLL_ADDR[j]);
    end

    always_comb begin
        kind_o = K_PLAIN;
        if (addr_i[1:0] != 2'b00)                                  kind_o = K_BAD;
        else if (addr_i == A_KEY)                                  kind_o = K_KEY;
        else if (|hit_set)                                         kind_o = K_SET;
        else if (|hit_clr)                                         kind_o = K_CLR;
        else if (addr_i == A_STRAP0 || addr_i == A_STRAP1)         kind_o = K_STRAP_SET;
        else if (addr_i == A_STRAP0 + AW'(4) ||
                 addr_i == A_STRAP1 + AW'(4))                      kind_o = K_STRAP_CLR;
        else if (|hit_pll)                                         kind_o = K_PLLX;
        else if (addr_i == A_RNG)                                  kind_o = K_RNG;
        else if (addr_i == A_REV0 || addr_i == A_REV1 ||
                 addr_i == A_ID0  || addr_i == A_ID1)              kind_o = K_RO;
    end
endmodule

// File: rtl/scb_bank.sv
module scb_bank
    import scb_pkg::*;
#(
    parameter int unsigned   AW       = 12,
    parameter logic [31:0]   KEY      = 32'h5A17_C3E9,
    parameter logic [31:0]   REV_WORD = 32'h0A11_0001
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          req_i,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [31:0]   wdata_i,
    input  logic [31:0]   rev_i,
    output logic          rvalid_o,
    output logic [31:0]   rdata_o,
    output logic          err_o,
    output logic          lock_hit_o
);
    localparam int unsigned IW     = AW - 2;
    localparam int unsigned NWORDS = 1 << IW;

    typedef struct packed {
        logic [NWORDS-1:0][DW-1:0] mem;
        logic                      rvalid;
        logic [DW-1:0]             rdata;
        logic                      err;
        logic                      lock;
    } bank_t;

    bank_t     q, d;
    acc_kind_e kind;
    logic [DW-1:0] rnd;
    logic [IW-1:0] widx, below_idx, prot_idx;

    scb_decode #(.AW(AW)) u_dec (
        .addr_i (addr_i),
        .kind_o (kind)
    );

    scb_lfsr #(.W(DW)) u_rng (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .state_o (rnd)
    );

    assign widx      = addr_i[AW-1:2];
    assign below_idx = widx - IW'(1);
    assign prot_idx  = widx + IW'(2);

    always_comb begin
        d        = q;
        d.rvalid = req_i;
        d.rdata  = '0;
        d.err    = 1'b0;
        d.lock   = 1'b0;
        if (req_i) begin
            if (kind == K_BAD) begin
                d.err = 1'b1;
            end else if (we_i) begin
                d.lock = (widx != '0) && (q.mem[0] == '0);
                unique case (kind)
                    K_KEY:       d.mem[0] = (wdata_i == KEY) ? DW'(1) : '0;
                    K_SET:       d.mem[widx] = q.mem[widx] | wdata_i;
                    K_CLR,
                    K_STRAP_CLR: d.mem[below_idx] = q.mem[below_idx] & ~wdata_i;
                    K_STRAP_SET: begin
                        if (q.mem[prot_idx] != '0) d.err = 1'b1;
                        else d.mem[widx] = q.mem[widx] | wdata_i;
                    end
                    K_RO,
                    K_RNG:       d.err = 1'b1;
                    default:     d.mem[widx] = wdata_i;
                endcase
            end else begin
                unique case (kind)
                    K_PLLX: begin
                        d.rdata           = q.mem[widx];
                        d.rdata[LOCK_BIT] = 1'b1;
                    end
                    K_RNG: begin
                        d.rdata       = rnd;
                        d.mem[widx]   = rnd;
                    end
                    default: d.rdata = q.mem[widx];
                endcase
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            q <= '0;
            q.mem[A_RST0[AW-1:2]]  <= RV_RST0;
            q.mem[A_RST1[AW-1:2]]  <= RV_RST1;
            q.mem[A_GATE0[AW-1:2]] <= RV_GATE0;
            q.mem[A_GATE1[AW-1:2]] <= RV_GATE1;
            q.mem[A_PLLH[AW-1:2]]  <= RV_PLLH;
            q.mem[A_ID0[AW-1:2]]   <= RV_ID0;
            q.mem[A_ID1[AW-1:2]]   <= RV_ID1;
            q.mem[A_REV0[AW-1:2]]  <= REV_WORD;
            q.mem[A_REV1[AW-1:2]]  <= rev_i;
        end else begin
            q <= d;
        end
    end

    assign rvalid_o   = q.rvalid;
    assign rdata_o    = q.rdata;
    assign err_o      = q.err;
    assign lock_hit_o = q.lock;

    a_r11_resp_follows: assert property (@(posedge clk_i) disable iff (rst_i)
        req_i |=> rvalid_o);
    a_r11_no_spurious: assert property (@(posedge clk_i) disable iff (rst_i)
        !req_i |=> !rvalid_o && !err_o && !lock_hit_o);
    a_r3_blocked_err: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_i && we_i && kind == K_STRAP_SET && q.mem[prot_idx] != '0) |=> err_o);
    a_r5_ro_err: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_i && we_i && (kind == K_RO || kind == K_RNG)) |=> err_o);
    a_r4_pll_lock: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_i && !we_i && kind == K_PLLX) |=> rdata_o[LOCK_BIT]);
    a_r10_bad_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_i && addr_i[1:0] != 2'b00) |=> (err_o && rdata_o == '0 && !lock_hit_o));
    a_r7_key_match: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_i && we_i && addr_i == A_KEY && wdata_i == KEY) |=> q.mem[0] == DW'(1));
    a_r8_lock_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_i && we_i && addr_i[1:0] == 2'b00 && addr_i != A_KEY && q.mem[0] == '0)
        |=> lock_hit_o);
endmodule

// File: tb/scb_bank_bench.sv
module scb_bank_bench;
    localparam logic [31:0] KEY  = 32'h5A17_C3E9;
    localparam logic [31:0] REVW = 32'h0A11_0001;
    localparam logic [31:0] REVI = 32'h0000_0A3C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        we  = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        rvalid, err, lock_hit;
    logic [31:0] rdata;

    always #2 clk = ~clk;

    scb_bank u_scb_bank (
        .clk_i (clk), .rst_i (rst), .req_i (req), .we_i (we),
        .addr_i (addr), .wdata_i (wdata), .rev_i (REVI),
        .rvalid_o (rvalid), .rdata_o (rdata), .err_o (err), .lock_hit_o (lock_hit)
    );

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    bit done = 0;

    // reference model
    logic [31:0] m [int];
    logic [31:0] rng;
    logic        e_rv, e_err, e_lk;
    logic [31:0] e_rd;
    string       tag;

    function automatic logic [31:0] mrd(int a);
        return m.exists(a) ? m[a] : 32'h0;
    endfunction

    function automatic bit is_set(int a);
        return a == 'h40 || a == 'h50 || a == 'h80 || a == 'h90;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m.delete();
            m['h40] = 32'hF7C3_FED8; m['h50] = 32'h0DFF_FFFC;
            m['h80] = 32'hFFFF_7F8A; m['h90] = 32'hFFF0_FFF0;
            m['h200] = 32'h1000_408F; m['h5B0] = 32'h1234_ABCD;
            m['h5B4] = 32'h8888_4444; m['h4] = REVW; m['h14] = REVI;
            rng = 32'h1;
            e_rv = 0; e_rd = 0; e_err = 0; e_lk = 0; tag = "R9";
        end else begin
            int a;
            a = int'(addr);
            e_rv = req; e_rd = 0; e_err = 0; e_lk = 0; tag = "R11";
            if (req) begin
                if (addr[1:0] != 2'b00) begin
                    e_err = 1; tag = "R10";
                end else if (we) begin
                    if (a != 0 && mrd(0) == 0) begin e_lk = 1; tag = "R8"; end
                    if (a == 0) begin m[0] = (wdata == KEY) ? 32'h1 : 32'h0; tag = "R7"; end
                    else if (is_set(a)) begin m[a] = mrd(a) | wdata; tag = "R1"; end
                    else if (is_set(a - 4)) begin m[a-4] = mrd(a-4) & ~wdata; tag = "R2"; end
                    else if (a == 'h500 || a == 'h510) begin
                        tag = "R3";
                        if (mrd(a + 8) != 0) e_err = 1;
                        else m[a] = mrd(a) | wdata;
                    end else if (a == 'h504 || a == 'h514) begin
                        m[a-4] = mrd(a-4) & ~wdata; tag = "R3";
                    end else if (a == 'h4 || a == 'h14 || a == 'h5B0 || a == 'h5B4 || a == 'h540) begin
                        e_err = 1; tag = "R5";
                    end else m[a] = wdata;
                end else begin
                    if (a == 'h204 || a == 'h224 || a == 'h244) begin
                        e_rd = mrd(a) | 32'h8000_0000; tag = "R4";
                    end else if (a == 'h540) begin
                        e_rd = rng; m[a] = rng; tag = "R6";
                    end else begin
                        e_rd = mrd(a);
                        if (a == 0) tag = "R7";
                        else if (a == 'h4 || a == 'h14 || a == 'h5B0 || a == 'h5B4) tag = "R5";
                    end
                end
            end
            rng = (rng >> 1) ^ (rng[0] ? 32'h8020_0003 : 32'h0);
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            vectors++;
            if (rvalid !== e_rv || rdata !== e_rd || err !== e_err || lock_hit !== e_lk) begin
                miscompares++;
                $display("FAIL %s: got rv=%0b rd=%08h err=%0b lk=%0b, expected rv=%0b rd=%08h err=%0b lk=%0b",
                         tag, rvalid, rdata, err, lock_hit, e_rv, e_rd, e_err, e_lk);
            end
        end
    end

    task automatic acc(input bit w, input logic [11:0] a, input logic [31:0] dt);
        @(negedge clk);
        req = 1; we = w; addr = a; wdata = dt;
        @(negedge clk);
        req = 0; we = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles >= 200000 && !done) begin
            miscompares++;
            $display("FAIL watchdog: got %0d cycles, expected completion", cycles);
            finish_run();
        end
    end

    localparam logic [11:0] POOL [16] = '{12'h000, 12'h004, 12'h014, 12'h040, 12'h044, 12'h050,
                                          12'h084, 12'h094, 12'h204, 12'h224, 12'h500, 12'h504,
                                          12'h508, 12'h514, 12'h540, 12'h3F8};

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        // R9 reset state
        foreach (POOL[i]) acc(0, POOL[i], 0);
        acc(0, 12'h080, 0); acc(0, 12'h090, 0); acc(0, 12'h200, 0);
        acc(0, 12'h5B0, 0); acc(0, 12'h5B4, 0);
        // R7 key, R8 lock pulse
        acc(1, 12'h000, 32'h1234_5678); acc(0, 12'h000, 0);
        acc(1, 12'h100, 32'hCAFE_0001); acc(0, 12'h100, 0);
        acc(1, 12'h000, KEY); acc(0, 12'h000, 0);
        // R1 set, R2 clear
        acc(1, 12'h050, 32'hF000_0003); acc(0, 12'h050, 0);
        acc(1, 12'h054, 32'h0F00_0001); acc(0, 12'h050, 0); acc(0, 12'h054, 0);
        acc(1, 12'h094, 32'hFFFF_FFFF); acc(1, 12'h090, 32'h0000_A5A5); acc(0, 12'h090, 0);
        // R3 strap
        acc(1, 12'h500, 32'h0000_00F0); acc(0, 12'h500, 0);
        acc(1, 12'h508, 32'h1);
        acc(1, 12'h500, 32'h0000_0F00); acc(0, 12'h500, 0);
        acc(1, 12'h504, 32'h0000_0030); acc(0, 12'h500, 0);
        acc(1, 12'h518, 32'h0); acc(1, 12'h510, 32'h8000_0001); acc(0, 12'h510, 0);
        // R4 PLL lock
        acc(1, 12'h224, 32'h0000_1234); acc(0, 12'h224, 0); acc(0, 12'h244, 0);
        // R5 read-only
        acc(1, 12'h004, 32'hFFFF_FFFF); acc(1, 12'h5B4, 0); acc(0, 12'h004, 0); acc(0, 12'h5B4, 0);
        // R6 random
        acc(0, 12'h540, 0); acc(0, 12'h540, 0); acc(1, 12'h540, 32'h5); acc(0, 12'h540, 0);
        // R10 misaligned
        acc(1, 12'h042, 32'hFFFF_FFFF); acc(0, 12'h041, 0); acc(0, 12'h040, 0);
        // R11 plain
        acc(1, 12'h7FC, 32'hDEAD_BEEF); acc(0, 12'h7FC, 0);
        // R8 after relock
        acc(1, 12'h000, 32'h0); acc(1, 12'h084, 32'h0000_0002); acc(0, 12'h080, 0);
        // mixed random stream
        for (int n = 0; n < 600; n++) begin
            logic [11:0] a;
            logic [31:0] dt;
            a  = POOL[$urandom_range(0, 15)];
            if ($urandom_range(0, 19) == 0) a = a | 12'(($urandom_range(1, 3)));
            dt = $urandom();
            if (a == 12'h000 && $urandom_range(0, 1) == 1) dt = KEY;
            if (a == 12'h508 && $urandom_range(0, 1) == 1) dt = 0;
            acc($urandom_range(0, 1) == 1, a, dt);
        end
        @(negedge clk);
        finish_run();
    end
endmodule